// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the receiving end of a serial programming link. A host drives a serial clock and a data line. The block answers on a return data line and turns the instructions it receives into write and read requests on a simple memory port. Every instruction is a frame of exactly four bytes, sent most significant bit first. The block samples the serial clock, the host data line and a separate active-low target reset on its own fast system clock, and it finds the serial clock edges itself.

The target does nothing until the host sends a valid unlock frame. While the third byte of any frame that begins with the unlock opcode is clocked in, the block shifts the second byte back out. The host uses this echo to confirm that both ends agree on the frame boundaries. Once unlocked, the block stages program words in a page buffer, one byte per frame, with the low byte of a word loaded before its high byte. A separate commit frame then writes the whole page to memory. It also supports single-byte writes to the data store and byte reads from either store.

Each commit or data-byte write holds a busy flag for a fixed number of clocks. Any frame that completes while the flag is set is dropped and flagged as an error.

Top module: `spt_target`

## Requirements
- R1: After system reset, `miso_o`, `enabled_o`, `busy_o`, `err_o` and `mem_we_o` are all 0.
- R2: Before the block is unlocked, any frame other than a correct unlock frame is ignored: no memory write occurs, `err_o` stays low and `enabled_o` stays 0.
- R3: A frame whose byte 1 is `OP_ENABLE` (default 0xAC) and whose byte 2 is `ENABLE_KEY` (default 0x53) sets `enabled_o` when the frame completes. For any frame whose byte 1 is `OP_ENABLE`, byte 2 as received is shifted out on `miso_o`, MSB first, during byte 3.
- R4: Host data is captured on rising serial clock edges and `miso_o` changes only after falling edges. In every byte slot other than the echo slot and the read slot, `miso_o` is 0.
- R5: Page-load frames use `OP_LOAD_LO` (0x40) or `OP_LOAD_HI` (0x48). The buffer word index is the low log2(`PAGE_WORDS`) bits of byte 3, and the data is byte 4. A commit frame uses `OP_WRITE_PAGE` (0x4C) with word address {byte 2, byte 3}. It writes all `PAGE_WORDS` buffer words, one per clock, starting at that address with its page-offset bits cleared.
- R6: A high-byte load for a word whose low byte has not been loaded since the last commit is discarded and pulses `err_o`.
- R7: Buffer words that were not loaded are written as 0xFFFF. After each page commit, the whole buffer returns to 0xFFFF with no low bytes marked.
- R8: `busy_o` is high for exactly `WRITE_CYCLES` clocks after a commit or data-byte write is accepted. Any frame that completes while `busy_o` is high is ignored and pulses `err_o`.
- R9: A data-byte write uses `OP_WRITE_EE` (0xC0) with the address taken from the low `EE_AW` bits of {byte 2, byte 3} and the data from byte 4. It produces one write cycle with `mem_space_o`=1, which fully replaces the stored byte.
- R10: Read frames use `OP_READ_LO` (0x20), `OP_READ_HI` (0x28) or `OP_READ_EE` (0xA0) with address {byte 2, byte 3}. They return the low program byte, the high program byte or the data byte on `miso_o` during byte 4.
- R11: Holding `tgt_rst_n_i` low clears the unlock state and the bit and byte position, so the next frame is received aligned from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host, asynchronous |
| tgt_rst_n_i | input | 1 | Target reset from host, active low, asynchronous |
| miso_o | output | 1 | Serial reply data to host |
| enabled_o | output | 1 | Unlock state |
| busy_o | output | 1 | Memory commit in progress |
| err_o | output | 1 | One-clock pulse on a rejected frame or byte load |
| mem_we_o | output | 1 | Memory write strobe |
| mem_space_o | output | 1 | Write target: 0 program store, 1 data store |
| mem_waddr_o | output | ADDR_W | Write address (word or byte) |
| mem_wdata_o | output | 16 | Write data (data store uses the low byte) |
| mem_raddr_o | output | ADDR_W | Read address |
| mem_rspace_o | output | 1 | Read target: 0 program store, 1 data store |
| mem_rdata_i | input | 16 | Combinational read data from memory |

## Verification
The bench builds the block with `PAGE_WORDS`=8, `ADDR_W`=10, `EE_AW`=6 and `WRITE_CYCLES`=600, and uses serial clock half periods of six system clocks. The short page lets a commit with a non-zero page offset, partly loaded and unloaded words, and the buffer erase after a commit all show up in a handful of frames. The small data address width makes address masking visible. With a busy window longer than one full frame, a frame sent right after a commit is certain to complete while the block is busy, which exercises the rejection path.

// File: rtl/spt_pkg.sv
package spt_pkg;

  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned BYTE_BITS  = 8;

  // Byte that arrived `back` bytes before the most recent one (0 = latest).
  function automatic logic [7:0] recent_byte(input logic [31:0] frame, input int unsigned back);
    return frame[BYTE_BITS*back +: BYTE_BITS];
  endfunction

  // True when the opcode selects one of the three read forms.
  function automatic logic is_read_op(input logic [7:0] op, input logic [7:0] op_lo,
                                      input logic [7:0] op_hi, input logic [7:0] op_ee);
    return (op == op_lo) || (op == op_hi) || (op == op_ee);
  endfunction

endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/spt_frame.sv
module spt_frame
  import spt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        sck_i,
  input  logic        mosi_i,
  input  logic        tx_load_i,
  input  logic [7:0]  tx_byte_i,
  output logic [31:0] frame_o,
  output logic        byte_end_o,
  output logic [1:0]  byte_idx_o,
  output logic        miso_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic             sck_d;
  logic             sck_rise, sck_fall;
  logic [31:0]      shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             byte_end_q;
  logic [7:0]       tx_q;
  logic             miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_i;
  end

  assign sck_rise = sck_i & ~sck_d;
  assign sck_fall = ~sck_i & sck_d;

  // receive side: one bit per rising edge, byte boundary pulse follows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      byte_end_q <= 1'b0;
    end else if (clr_i) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      byte_end_q <= 1'b0;
    end else begin
      byte_end_q <= 1'b0;
      if (sck_rise) begin
        shift_q    <= {shift_q[30:0], mosi_i};
        cnt_q      <= cnt_q + 1'b1;
        byte_end_q <= (cnt_q[2:0] == 3'd7);
      end
    end
  end

  // transmit side: loaded at a byte boundary, advanced on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (clr_i) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (tx_load_i) begin
      tx_q <= tx_byte_i;
    end else if (sck_fall) begin
      miso_q <= tx_q[7];
      tx_q   <= {tx_q[6:0], 1'b0};
    end
  end

  assign frame_o    = shift_q;
  assign byte_end_o = byte_end_q;
  assign byte_idx_o = cnt_q[CNT_W-1:3];
  assign miso_o     = miso_q;

endmodule

// File: rtl/spt_commit.sv
module spt_commit #(
  parameter int unsigned PAGE_WORDS   = 64,
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned WRITE_CYCLES = 2000,
  localparam int unsigned PG_AW       = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [PG_AW-1:0]  ld_idx_i,
  input  logic [7:0]        ld_data_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic              eb_wr_i,
  input  logic [ADDR_W-1:0] eb_addr_i,
  input  logic [7:0]        eb_data_i,
  output logic              busy_o,
  output logic              hi_reject_o,
  output logic              mem_we_o,
  output logic              mem_space_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [15:0]       mem_wdata_o
);

  localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);

  logic [15:0]           pg_buf [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] lo_ok_q;
  logic                  hi_rej_q;
  logic                  busy_q, stream_q, eb_q, space_q;
  logic [PG_AW-1:0]      widx_q;
  logic [ADDR_W-1:0]     base_q, eb_addr_q;
  logic [7:0]            eb_data_q;
  logic [CW-1:0]         wcnt_q;
  logic                  last_cycle;

  assign last_cycle = busy_q && (wcnt_q == CW'(WRITE_CYCLES - 1));

  // page buffer with per-word low-byte marks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_WORDS; i++) pg_buf[i] <= 16'hFFFF;
      lo_ok_q  <= '0;
      hi_rej_q <= 1'b0;
    end else begin
      hi_rej_q <= 1'b0;
      if (last_cycle && !space_q) begin
        for (int i = 0; i < PAGE_WORDS; i++) pg_buf[i] <= 16'hFFFF;
        lo_ok_q <= '0;
      end else if (ld_lo_i) begin
        pg_buf[ld_idx_i][7:0] <= ld_data_i;
        lo_ok_q[ld_idx_i]     <= 1'b1;
      end else if (ld_hi_i) begin
        if (lo_ok_q[ld_idx_i]) pg_buf[ld_idx_i][15:8] <= ld_data_i;
        else                   hi_rej_q <= 1'b1;
      end
    end
  end

  // commit sequencer: stream the page, then hold busy for the write time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      stream_q  <= 1'b0;
      eb_q      <= 1'b0;
      space_q   <= 1'b0;
      widx_q    <= '0;
      base_q    <= '0;
      eb_addr_q <= '0;
      eb_data_q <= '0;
      wcnt_q    <= '0;
    end else begin
      eb_q <= 1'b0;
      if (commit_i) begin
        busy_q   <= 1'b1;
        stream_q <= 1'b1;
        space_q  <= 1'b0;
        widx_q   <= '0;
        wcnt_q   <= '0;
        base_q   <= commit_addr_i & ~ADDR_W'(PAGE_WORDS - 1);
      end else if (eb_wr_i) begin
        busy_q    <= 1'b1;
        eb_q      <= 1'b1;
        space_q   <= 1'b1;
        wcnt_q    <= '0;
        eb_addr_q <= eb_addr_i;
        eb_data_q <= eb_data_i;
      end else if (busy_q) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (last_cycle) busy_q <= 1'b0;
        if (stream_q) begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == PG_AW'(PAGE_WORDS - 1)) stream_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign hi_reject_o = hi_rej_q;
  assign mem_we_o    = stream_q | eb_q;
  assign mem_space_o = eb_q;
  assign mem_waddr_o = eb_q ? eb_addr_q : (base_q | ADDR_W'(widx_q));
  assign mem_wdata_o = eb_q ? {8'h00, eb_data_q} : pg_buf[widx_q];

endmodule

// File: rtl/spt_target.sv
module spt_target
  import spt_pkg::*;
#(
  parameter int unsigned PAGE_WORDS    = 64,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned EE_AW         = 9,
  parameter int unsigned WRITE_CYCLES  = 2000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter logic [7:0]  OP_ENABLE     = 8'hAC,
  parameter logic [7:0]  ENABLE_KEY    = 8'h53,
  parameter logic [7:0]  OP_LOAD_LO    = 8'h40,
  parameter logic [7:0]  OP_LOAD_HI    = 8'h48,
  parameter logic [7:0]  OP_WRITE_PAGE = 8'h4C,
  parameter logic [7:0]  OP_WRITE_EE   = 8'hC0,
  parameter logic [7:0]  OP_READ_LO    = 8'h20,
  parameter logic [7:0]  OP_READ_HI    = 8'h28,
  parameter logic [7:0]  OP_READ_EE    = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              tgt_rst_n_i,
  output logic              miso_o,
  output logic              enabled_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_we_o,
  output logic              mem_space_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [15:0]       mem_wdata_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              mem_rspace_o,
  input  logic [15:0]       mem_rdata_i
);

  localparam int unsigned PG_AW = $clog2(PAGE_WORDS);

  logic [2:0]  sync_q;
  logic        clr;
  logic [31:0] frame;
  logic        byte_end;
  logic [1:0]  byte_idx;
  logic [7:0]  tx_byte, rd_byte;
  logic        enabled_q, busy_err_q, busy, hi_reject;

  // named internal events
  logic frame_end, echo_evt, read_evt, accept;
  logic ld_lo, ld_hi, commit, eb_wr;
  logic [7:0] fe_op;

  spt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({tgt_rst_n_i, mosi_i, sck_i}),
    .q_o   (sync_q)
  );

  assign clr = ~sync_q[2];

  spt_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .sck_i      (sync_q[0]),
    .mosi_i     (sync_q[1]),
    .tx_load_i  (byte_end),
    .tx_byte_i  (tx_byte),
    .frame_o    (frame),
    .byte_end_o (byte_end),
    .byte_idx_o (byte_idx),
    .miso_o     (miso_o)
  );

  // byte-slot events
  assign frame_end = byte_end && (byte_idx == 2'd0);
  assign echo_evt  = byte_end && (byte_idx == 2'd2) && (recent_byte(frame, 1) == OP_ENABLE);
  assign read_evt  = byte_end && (byte_idx == 2'd3) && enabled_q && !busy &&
                     is_read_op(recent_byte(frame, 2), OP_READ_LO, OP_READ_HI, OP_READ_EE);

  // read path: address is the two most recent bytes when byte 3 closes
  assign mem_rspace_o = (frame[23:16] == OP_READ_EE);
  assign mem_raddr_o  = mem_rspace_o ? ADDR_W'(frame[EE_AW-1:0]) : frame[ADDR_W-1:0];
  assign rd_byte      = (frame[23:16] == OP_READ_HI) ? mem_rdata_i[15:8] : mem_rdata_i[7:0];

  assign tx_byte = echo_evt ? recent_byte(frame, 0) :
                   read_evt ? rd_byte : 8'h00;

  // frame-end decode
  assign fe_op  = recent_byte(frame, 3);
  assign accept = frame_end && enabled_q && !busy && !clr;
  assign ld_lo  = accept && (fe_op == OP_LOAD_LO);
  assign ld_hi  = accept && (fe_op == OP_LOAD_HI);
  assign commit = accept && (fe_op == OP_WRITE_PAGE);
  assign eb_wr  = accept && (fe_op == OP_WRITE_EE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled_q  <= 1'b0;
      busy_err_q <= 1'b0;
    end else begin
      busy_err_q <= 1'b0;
      if (clr) begin
        enabled_q <= 1'b0;
      end else if (frame_end) begin
        if (!enabled_q)
          enabled_q <= (fe_op == OP_ENABLE) && (recent_byte(frame, 2) == ENABLE_KEY);
        else if (busy)
          busy_err_q <= 1'b1;
      end
    end
  end

  spt_commit #(
    .PAGE_WORDS   (PAGE_WORDS),
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_commit (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_lo_i       (ld_lo),
    .ld_hi_i       (ld_hi),
    .ld_idx_i      (frame[8 +: PG_AW]),
    .ld_data_i     (frame[7:0]),
    .commit_i      (commit),
    .commit_addr_i (frame[8 +: ADDR_W]),
    .eb_wr_i       (eb_wr),
    .eb_addr_i     (ADDR_W'(frame[8 +: EE_AW])),
    .eb_data_i     (frame[7:0]),
    .busy_o        (busy),
    .hi_reject_o   (hi_reject),
    .mem_we_o      (mem_we_o),
    .mem_space_o   (mem_space_o),
    .mem_waddr_o   (mem_waddr_o),
    .mem_wdata_o   (mem_wdata_o)
  );

  assign enabled_o = enabled_q;
  assign busy_o    = busy;
  assign err_o     = busy_err_q | hi_reject;

endmodule

// File: rtl/spt_chk.sv
module spt_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic enabled_o,
  input logic mem_we_o,
  input logic mem_space_o,
  input logic frame_end,
  input logic busy_err_q
);

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err_q |-> $past(busy_o));

  // R5
  write_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  // R2
  commit_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(enabled_o));

  // R3
  unlock_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled_o) |-> $past(frame_end));

  // R9
  single_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_space_o) |=> !mem_we_o);

endmodule

bind spt_target spt_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .enabled_o   (enabled_o),
  .mem_we_o    (mem_we_o),
  .mem_space_o (mem_space_o),
  .frame_end   (frame_end),
  .busy_err_q  (busy_err_q)
);

// File: tb/spt_target_tb.sv
module spt_target_tb_top;

  localparam int unsigned PW   = 8;
  localparam int unsigned AW   = 10;
  localparam int unsigned EAW  = 6;
  localparam int unsigned WC   = 600;
  localparam int unsigned HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, tgt_rst_n = 1'b1;
  logic miso, enabled, busy, err, we, wspace, rspace;
  logic [AW-1:0] waddr, raddr;
  logic [15:0] wdata, rdata;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, err_cnt = 0, busy_cyc = 0;

  logic [15:0] pmem [1<<AW];
  logic [7:0]  emem [1<<EAW];

  always #5 clk = ~clk;

  spt_target #(.PAGE_WORDS(PW), .ADDR_W(AW), .EE_AW(EAW), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .tgt_rst_n_i(tgt_rst_n),
    .miso_o(miso), .enabled_o(enabled), .busy_o(busy), .err_o(err),
    .mem_we_o(we), .mem_space_o(wspace), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .mem_raddr_o(raddr), .mem_rspace_o(rspace), .mem_rdata_i(rdata)
  );

  // behavioural memory and event counters
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) pmem[i] <= 16'hFFFF;
      for (int i = 0; i < (1<<EAW); i++) emem[i] <= 8'hFF;
    end else if (we) begin
      if (wspace) emem[waddr[EAW-1:0]] <= wdata[7:0];
      else        pmem[waddr] <= wdata;
    end
    if (we)   we_cnt   <= we_cnt + 1;
    if (err)  err_cnt  <= err_cnt + 1;
    if (busy) busy_cyc <= busy_cyc + 1;
  end

  assign rdata = rspace ? {8'h00, emem[raddr[EAW-1:0]]} : pmem[raddr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) begin
      mosi = f[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (WC + 40) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 miso", miso, 0);
    check("R1 enabled", enabled, 0);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);
    check("R1 we", we, 0);
  endtask

  task automatic t_locked();
    logic [31:0] r;
    int w0 = we_cnt, e0 = err_cnt;
    xfer(32'h4000_0012, r);
    check("R2 reply zero", r, 0);
    xfer(32'h4C00_0000, r);
    xfer(32'hC000_0111, r);
    repeat (20) @(negedge clk);
    check("R2 no write", we_cnt - w0, 0);
    check("R2 no err", err_cnt - e0, 0);
    check("R2 still locked", enabled, 0);
  endtask

  task automatic t_enable();
    logic [31:0] r;
    xfer(32'hAC55_0000, r);
    check("R3 echo of wrong key", r, 32'h0000_5500);
    check("R3 wrong key stays locked", enabled, 0);
    xfer(32'hAC53_0000, r);
    check("R3 R4 echo slot only", r, 32'h0000_5300);
    check("R3 unlocked", enabled, 1);
  endtask

  task automatic t_page();
    logic [31:0] r;
    int w0, e0, b0;
    for (int i = 0; i < 3; i++) begin
      xfer({8'h40, 8'h00, 8'(i), 8'(8'h10 + i)}, r);
      xfer({8'h48, 8'h00, 8'(i), 8'(8'hA0 + i)}, r);
    end
    e0 = err_cnt;
    xfer(32'h4800_03AB, r);           // high before low
    check("R6 hi-first rejected", err_cnt - e0, 1);
    xfer(32'h4000_03CD, r);
    w0 = we_cnt; b0 = busy_cyc;
    xfer(32'h4C00_0B00, r);           // offset 3 inside page at 8
    check("R8 busy after commit", busy, 1);
    settle();
    check("R8 busy length", busy_cyc - b0, WC);
    check("R5 page write count", we_cnt - w0, PW);
    check("R5 word0", pmem[8], 16'hA010);
    check("R5 word2", pmem[10], 16'hA212);
    check("R6 high kept erased", pmem[11], 16'hFFCD);
    check("R7 unloaded word", pmem[15], 16'hFFFF);
    check("R5 outside page", pmem[16], 16'hFFFF);
  endtask

  task automatic t_erased();
    logic [31:0] r;
    xfer(32'h4000_0155, r);
    xfer(32'h4800_0166, r);
    xfer(32'h4C00_0800, r);
    settle();
    check("R7 buffer erased", pmem[8], 16'hFFFF);
    check("R7 reloaded word", pmem[9], 16'h6655);
  endtask

  task automatic t_busy();
    logic [31:0] r;
    int e0;
    xfer(32'h4C00_1800, r);
    e0 = err_cnt;
    xfer(32'hC000_055A, r);
    check("R8 frame while busy flagged", err_cnt - e0, 1);
    settle();
    check("R8 frame while busy ignored", emem[5], 8'hFF);
  endtask

  task automatic t_eeprom();
    logic [31:0] r;
    int w0 = we_cnt;
    xfer(32'hC000_473C, r);           // 0x47 masks to location 7
    settle();
    check("R9 one write", we_cnt - w0, 1);
    check("R9 stored", emem[7], 8'h3C);
    xfer(32'hC000_07A5, r);
    settle();
    check("R9 replaced", emem[7], 8'hA5);
  endtask

  task automatic t_read();
    logic [31:0] r;
    xfer(32'h2000_0900, r);
    check("R10 read low", r, 32'h0000_0055);
    xfer(32'h2800_0900, r);
    check("R10 read high", r, 32'h0000_0066);
    xfer(32'hA000_0700, r);
    check("R10 read data store", r, 32'h0000_00A5);
  endtask

  task automatic t_tgt_reset();
    logic [31:0] r;
    for (int i = 0; i < 11; i++) begin
      mosi = i[0];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    tgt_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 unlock cleared", enabled, 0);
    tgt_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    xfer(32'hAC53_0000, r);
    check("R11 realigned echo", r, 32'h0000_5300);
    check("R11 unlocked again", enabled, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_locked();
    t_enable();
    t_page();
    t_erased();
    t_busy();
    t_eeprom();
    t_read();
    t_tgt_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule